// File: doc/BRIEF.md
# Linked Control-Block DMA Channel

A single memory-to-memory and peripheral DMA channel that takes its work from a chain of control blocks kept in system memory. Software places one or more 32-byte aligned blocks in memory, writes the address of the first one into the block-address register and sets the run bit. The channel reads the block, moves its payload one 32-bit word at a time over a simple request/grant memory port, and then follows the block's next pointer. A next pointer of zero ends the chain. A next pointer that leads back to an earlier block makes a loop that never ends. Software uses such a loop for streaming buffers.

A block is eight 32-bit words: transfer control, source address, destination address, byte length, stride, next-block address and two unused pad words. The channel reads only the first six. The control word selects whether each address advances, whether reads or writes are skipped, whether each word is paced by a peripheral request line, how many idle cycles come before each word, whether the block end waits for write responses, and whether the block end raises the interrupt. Software can pause the channel, cut the current block short, or return the channel to idle through the status/control register.

Top module: `dma_cb_channel`

## Requirements
- R1: After the reset pin is released, the control/status register (offset 0x00) reads 0x10, which is paused with nothing else set, while all request lines are low. The block-address register (0x04) reads 0 and `irq` is low.
- R2: Writing a block address to 0x04 while the channel is idle stores it with its low five bits cleared. Setting the run bit (0x00 bit 0) then reads six words from that address upward in 4-byte steps. These land in the read-only copies at 0x08 (control), 0x0C (source), 0x10 (destination), 0x14 (length), 0x18 (stride) and 0x1C (next).
- R3: Each word is read from the source and written to the destination. The source advances by 4 after each word only when control bit 8 is set, and the destination advances by 4 only when control bit 4 is set. The length copy counts down by 4 bytes per word, and the block ends when it reaches 0. At the end, 0x0C and 0x10 show the final addresses and 0x14 shows 0.
- R4: At a block end the next value is loaded into 0x04. A nonzero value starts the next block. A value of zero leaves 0x04 at 0, stops all memory requests, and leaves the run bit reading 1.
- R5: Every block end sets END (0x00 bit 1). A block whose control bit 0 is set also sets INT (0x00 bit 2), which drives `irq`. Writing 1 to either bit clears it. Writing 0x5 clears INT and keeps the channel running.
- R6: With control bit 11 set, the channel reads no data from the source and writes zeros.
- R7: With control bit 7 set, the channel writes nothing to the destination but still performs the source reads.
- R8: With control bit 10 or bit 6 set, each word waits until `dreq[m]` is high, where m is control bits 20:16. 0x00 bit 5 reads 1 while the channel is stalled on that line, and 0x00 bit 3 shows the level of that line.
- R9: Control bits 25:21 give N, and at least N cycles with no memory request pass before each word of the block starts.
- R10: Writing 0 to the run bit lets the request in flight finish and issues no further requests until the bit is set again, after which the channel resumes. While paused, 0x00 bit 4 reads 1. 0x00 bit 6 reads 1 exactly while granted writes still await their response.
- R11: In a block with control bit 3 set, the block end (and any load of the next block address) waits until every write response has returned.
- R12: Writing 0x00 with bit 30 and bit 0 set ends the current block at the next word boundary. The channel then signals the block end as usual and moves on to the next block.
- R13: Writing 0x00 with bit 31 set returns the channel to idle: 0x04 reads 0, and the run, END and INT bits read 0. No further memory requests are made.
- R14: A chain whose last next pointer leads back to its first block runs without end, raising INT at each block end that has control bit 0 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request valid, held until granted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mem_bvalid | input | 1 | One write response returned |
| dreq | input | 32 | Peripheral request lines |
| irq | output | 1 | Interrupt, equal to the INT bit |

## Verification
The bench drives a memory model with random grants and random read and write-response latency, and mirrors the outstanding-write count to judge the write-wait bit and the block-end drain. It targets a two-block chain ending at a zero pointer: an unlinked channel would leave the second destination unwritten or keep issuing requests. Zero fill and skipped writes are checked through the read and write counts, because a channel that ignores them would touch memory it must not. A stalled peripheral line, a pause with slow write responses, an abort in the middle of a long block, and a looping chain followed by a channel reset are each checked for the stall bit, for requests that should not appear, for a sentinel word the aborted block must not reach, and for the interrupt count of the loop.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  localparam int WORD_W = 32;
  localparam int MAP_W  = 5;
  localparam int GAP_W  = 5;
  localparam int NREQ   = 1 << MAP_W;

  // control word bit positions
  localparam int TI_IEN   = 0;
  localparam int TI_WRESP = 3;
  localparam int TI_DINC  = 4;
  localparam int TI_DPACE = 6;
  localparam int TI_DSKIP = 7;
  localparam int TI_SINC  = 8;
  localparam int TI_SPACE = 10;
  localparam int TI_SSKIP = 11;
  localparam int TI_MAPLO = 16;
  localparam int TI_GAPLO = 21;

  // status/control bit positions
  localparam int CS_RUN   = 0;
  localparam int CS_END   = 1;
  localparam int CS_INT   = 2;
  localparam int CS_ABORT = 30;
  localparam int CS_RST   = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FRSP, ST_GAP, ST_PACE,
    ST_RREQ, ST_RRSP, ST_WREQ, ST_DRAIN, ST_NEXT
  } state_t;
endpackage

// File: rtl/dma_wr_track.sv
module dma_wr_track #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic retire,
  output logic busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (issue && !retire)      cnt_d = cnt_q + 1'b1;
    else if (retire && !issue) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = |cnt_q;

  // R10
  wr_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |-> !(issue && !retire));

  // R10
  wr_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !(retire && !issue));
endmodule

// File: rtl/dma_pace.sv
module dma_pace
  import dma_ch_pkg::*;
#(
  parameter int CW = GAP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] dreq,
  input  logic [MAP_W-1:0] map,
  input  logic            gap_load,
  input  logic [CW-1:0]   gap_val,
  input  logic            gap_en,
  output logic            gap_zero,
  output logic            line
);
  logic [CW-1:0] gap_q, gap_d;

  always_comb begin
    gap_d = gap_q;
    if (gap_load)                gap_d = gap_val;
    else if (gap_en && !gap_zero) gap_d = gap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_d;
  end

  assign gap_zero = (gap_q == '0);
  assign line     = dreq[map];

  // R9
  gap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_en && !gap_load && !gap_zero) |=> (gap_q == $past(gap_q) - 1'b1));
endmodule

// File: rtl/dma_cb_channel.sv
module dma_cb_channel
  import dma_ch_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [5:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_bvalid,
  input  logic [NREQ-1:0]   dreq,
  output logic              irq
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(4);
  localparam logic [WORD_W-1:0] ALIGN_MASK = ~WORD_W'(31);

  state_t            st_q, st_d;
  logic              run_q, run_d, end_q, end_d, int_q, int_d, abt_q, abt_d;
  logic [WORD_W-1:0] cb_q, cb_d, ti_q, ti_d, src_q, src_d, dst_q, dst_d;
  logic [WORD_W-1:0] len_q, len_d, str_q, str_d, nxt_q, nxt_d, dat_q, dat_d;
  logic [2:0]        idx_q, idx_d;

  logic cs_wr, rst_cmd, cb_wr, step, gap_load, gap_en, gap_zero, line;
  logic paced, held, wr_busy;

  assign cs_wr   = reg_wr && (reg_addr == 6'h00);
  assign rst_cmd = cs_wr && reg_wdata[CS_RST];
  assign cb_wr   = reg_wr && (reg_addr == 6'h04) && (st_q == ST_IDLE);
  assign paced   = ti_q[TI_SPACE] || ti_q[TI_DPACE];
  assign held    = (st_q == ST_PACE) && paced && !line;

  dma_wr_track #(.CNT_W(OUT_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .issue(mem_req && mem_we && mem_gnt),
    .retire(mem_bvalid), .busy(wr_busy)
  );

  dma_pace u_pace (
    .clk(clk), .rst_n(rst_n), .dreq(dreq),
    .map(ti_q[TI_MAPLO +: MAP_W]),
    .gap_load(gap_load), .gap_val(ti_q[TI_GAPLO +: GAP_W]),
    .gap_en(gap_en), .gap_zero(gap_zero), .line(line)
  );

  always_comb begin
    st_d = st_q; run_d = run_q; end_d = end_q; int_d = int_q; abt_d = abt_q;
    cb_d = cb_q; ti_d = ti_q; src_d = src_q; dst_d = dst_q; len_d = len_q;
    str_d = str_q; nxt_d = nxt_q; dat_d = dat_q; idx_d = idx_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = src_q; mem_wdata = dat_q;
    step = 1'b0; gap_load = 1'b0; gap_en = 1'b0;

    if (cs_wr) begin
      run_d = reg_wdata[CS_RUN];
      if (reg_wdata[CS_END]) end_d = 1'b0;
      if (reg_wdata[CS_INT]) int_d = 1'b0;
      if (reg_wdata[CS_ABORT] && st_q != ST_IDLE) abt_d = 1'b1;
    end
    if (cb_wr) cb_d = reg_wdata & ALIGN_MASK;

    case (st_q)
      ST_IDLE: if (run_q && cb_q != '0) begin
        st_d  = ST_FREQ;
        idx_d = '0;
      end
      ST_FREQ: begin
        mem_req  = 1'b1;
        mem_addr = cb_q + {27'b0, idx_q, 2'b00};
        if (mem_gnt) st_d = ST_FRSP;
      end
      ST_FRSP: if (mem_rvalid) begin
        case (idx_q)
          3'd0:    ti_d  = mem_rdata;
          3'd1:    src_d = mem_rdata;
          3'd2:    dst_d = mem_rdata;
          3'd3:    len_d = mem_rdata;
          3'd4:    str_d = mem_rdata;
          default: nxt_d = mem_rdata;
        endcase
        if (idx_q == 3'd5) begin
          st_d     = ST_GAP;
          gap_load = 1'b1;
        end else begin
          idx_d = idx_q + 3'd1;
          st_d  = ST_FREQ;
        end
      end
      ST_GAP: begin
        if (len_q == '0 || abt_q) st_d = ST_DRAIN;
        else if (run_q) begin
          if (gap_zero) st_d = ST_PACE;
          else          gap_en = 1'b1;
        end
      end
      ST_PACE: if (run_q && (!paced || line)) begin
        if (!ti_q[TI_SSKIP])      st_d = ST_RREQ;
        else begin
          dat_d = '0;
          if (ti_q[TI_DSKIP]) step = 1'b1;
          else                st_d = ST_WREQ;
        end
      end
      ST_RREQ: begin
        mem_req = 1'b1;
        if (mem_gnt) st_d = ST_RRSP;
      end
      ST_RRSP: if (mem_rvalid) begin
        dat_d = mem_rdata;
        if (ti_q[TI_DSKIP]) step = 1'b1;
        else                st_d = ST_WREQ;
      end
      ST_WREQ: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_q;
        if (mem_gnt) step = 1'b1;
      end
      ST_DRAIN: if (!ti_q[TI_WRESP] || !wr_busy) st_d = ST_NEXT;
      default: begin
        end_d = 1'b1;
        if (ti_q[TI_IEN]) int_d = 1'b1;
        cb_d  = nxt_q;
        abt_d = 1'b0;
        st_d  = ST_IDLE;
      end
    endcase

    if (step) begin
      if (ti_q[TI_SINC]) src_d = src_q + STEP;
      if (ti_q[TI_DINC]) dst_d = dst_q + STEP;
      len_d    = (len_q > STEP) ? len_q - STEP : '0;
      st_d     = ST_GAP;
      gap_load = 1'b1;
    end

    if (rst_cmd) begin
      st_d = ST_IDLE; run_d = 1'b0; end_d = 1'b0; int_d = 1'b0;
      abt_d = 1'b0; cb_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; run_q <= 1'b0; end_q <= 1'b0; int_q <= 1'b0; abt_q <= 1'b0;
      cb_q <= '0; ti_q <= '0; src_q <= '0; dst_q <= '0; len_q <= '0;
      str_q <= '0; nxt_q <= '0; dat_q <= '0; idx_q <= '0;
    end else begin
      st_q <= st_d; run_q <= run_d; end_q <= end_d; int_q <= int_d; abt_q <= abt_d;
      cb_q <= cb_d; ti_q <= ti_d; src_q <= src_d; dst_q <= dst_d; len_q <= len_d;
      str_q <= str_d; nxt_q <= nxt_d; dat_q <= dat_d; idx_q <= idx_d;
    end
  end

  always_comb begin
    case (reg_addr)
      6'h00:   reg_rdata = {25'b0, wr_busy, held, !run_q, line, int_q, end_q, run_q};
      6'h04:   reg_rdata = cb_q;
      6'h08:   reg_rdata = ti_q;
      6'h0C:   reg_rdata = src_q;
      6'h10:   reg_rdata = dst_q;
      6'h14:   reg_rdata = len_q;
      6'h18:   reg_rdata = str_q;
      6'h1C:   reg_rdata = nxt_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = int_q;

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_q == '0) |-> !mem_req);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !rst_cmd) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R6
  no_src_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && st_q != ST_FREQ) |-> !ti_q[TI_SSKIP]);

  // R7
  no_dst_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !ti_q[TI_DSKIP]);

  // R5
  int_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q) |-> $past(st_q == ST_NEXT));

  // R11
  drain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NEXT && ti_q[TI_WRESP]) |-> !wr_busy);
endmodule

// File: tb/dma_cb_channel_test.sv
module dma_cb_channel_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_bvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] dreq = '0;
  logic        irq;

  int total = 0, bad = 0;
  int cyc = 0, out_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  int wlat_min = 1, wlat_rng = 8;
  int idle_run = 0, min_idle = 1000;
  bit idle_open = 0, rd_busy = 0, dreq_rand = 0, finished = 0;
  int rd_due = 0;
  logic [31:0] rd_addr = '0;
  int wq[$];
  logic [31:0] mem [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cb_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_bvalid(mem_bvalid), .dreq(dreq), .irq(irq)
  );

  // behavioural memory with random grant and latencies
  always @(posedge clk) begin
    cyc++;
    if (mem_bvalid) out_cnt--;
    if (mem_req) begin
      if (idle_open && idle_run < min_idle) min_idle = idle_run;
      idle_open = 0;
    end else idle_run++;
    mem_rvalid <= 1'b0;
    mem_bvalid <= 1'b0;
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        wq.push_back(cyc + wlat_min + int'($urandom % wlat_rng));
        wr_cnt++; out_cnt++;
        idle_open = 1; idle_run = 0;
      end else begin
        rd_addr = mem_addr;
        rd_due  = cyc + 1 + int'($urandom % 3);
        rd_busy = 1;
        if (mem_addr >= 32'h400) rd_cnt++;
      end
    end
    if (rd_busy && cyc >= rd_due) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[rd_addr[11:2]];
      rd_busy = 0;
    end
    if (wq.size() > 0 && wq[0] <= cyc) begin
      mem_bvalid <= 1'b1;
      void'(wq.pop_front());
    end
    mem_gnt <= ($urandom % 4) != 0;
    if (dreq_rand) dreq[5] <= $urandom % 2;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin
      rd(6'h04, v);
      n++;
    end while (v != 0 && n < 5000);
  endtask

  task automatic put_cb(input int a, input logic [31:0] ti, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] l, input logic [31:0] nx);
    mem[a/4] = ti; mem[a/4+1] = s; mem[a/4+2] = d;
    mem[a/4+3] = l; mem[a/4+4] = 32'h0; mem[a/4+5] = nx;
  endtask

  task automatic chk_copy(input string tag, input int s, input int d, input int words);
    for (int i = 0; i < words; i++) chk(tag, mem[d/4+i], mem[s/4+i]);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int snap, cnt;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h1000_0000 + i * 32'h0101_0003;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, v); chk("R1 cs", v, 32'h10);
    rd(6'h04, v); chk("R1 cb", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 R3 R4 R5 R11 two-block copy chain
    wlat_min = 4;
    put_cb(32'h100, 32'h119, 32'h400, 32'h800, 16, 32'h120);
    put_cb(32'h120, 32'h119, 32'h440, 32'h840, 8, 32'h0);
    wr(6'h04, 32'h10F);
    rd(6'h04, v); chk("R2 cb align", v, 32'h100);
    wr(6'h00, 32'h1);
    wait_idle();
    chk("R11 responses drained", out_cnt, 0);
    wlat_min = 1;
    chk_copy("R3 copy blk0", 32'h400, 32'h800, 4);
    chk_copy("R4 copy blk1", 32'h440, 32'h840, 2);
    rd(6'h08, v); chk("R2 ti copy", v, 32'h119);
    rd(6'h1C, v); chk("R2 next copy", v, 32'h0);
    rd(6'h0C, v); chk("R3 src end", v, 32'h448);
    rd(6'h14, v); chk("R3 len end", v, 32'h0);
    rd(6'h00, v); chk("R4 R5 cs after chain", v & 32'h7, 32'h7);
    chk("R5 irq set", {31'b0, irq}, 32'h1);
    wr(6'h00, 32'h5);
    rd(6'h00, v); chk("R5 int cleared", v & 32'h7, 32'h3);
    chk("R5 irq low", {31'b0, irq}, 32'h0);
    wr(6'h00, 32'h3);
    rd(6'h00, v); chk("R5 end cleared", v & 32'h7, 32'h1);

    // R6 zero fill
    for (int i = 0; i < 3; i++) mem[32'h900/4+i] = 32'hFFFF_FFFF;
    put_cb(32'h140, 32'h818, 32'h400, 32'h900, 12, 32'h0);
    rd_cnt = 0;
    wr(6'h04, 32'h140); wr(6'h00, 32'h1);
    wait_idle();
    chk("R6 no source reads", rd_cnt, 0);
    for (int i = 0; i < 3; i++) chk("R6 zero data", mem[32'h900/4+i], 32'h0);

    // R7 skipped writes
    mem[32'hA00/4] = 32'h5A5A_5A5A; mem[32'hA04/4] = 32'h5A5A_5A5A;
    put_cb(32'h160, 32'h180, 32'h400, 32'hA00, 8, 32'h0);
    rd_cnt = 0; wr_cnt = 0;
    wr(6'h04, 32'h160); wr(6'h00, 32'h1);
    wait_idle();
    chk("R7 reads done", rd_cnt, 2);
    chk("R7 no writes", wr_cnt, 0);
    chk("R7 dst untouched", mem[32'hA04/4], 32'h5A5A_5A5A);

    // R8 peripheral pacing, fixed destination
    put_cb(32'h180, 32'h0005_0148, 32'h400, 32'hC00, 16, 32'h0);
    rd_cnt = 0; wr_cnt = 0;
    wr(6'h04, 32'h180); wr(6'h00, 32'h1);
    repeat (30) @(negedge clk);
    rd(6'h00, v); chk("R8 held", (v >> 5) & 1, 32'h1);
    chk("R8 line low", (v >> 3) & 1, 32'h0);
    chk("R8 stalled no data", rd_cnt + wr_cnt, 0);
    @(negedge clk); dreq = 32'h20;
    #1 chk("R8 line high", (reg_rdata >> 3) & 1, 32'h1);
    dreq_rand = 1;
    wait_idle();
    dreq_rand = 0;
    @(negedge clk); dreq = 32'h0;
    chk("R8 writes", wr_cnt, 4);
    chk("R3 fixed dst last word", mem[32'hC00/4], mem[32'h40C/4]);

    // R9 wait cycles
    put_cb(32'h1A0, 32'h00C0_0110, 32'h400, 32'hB00, 12, 32'h0);
    min_idle = 1000;
    wr(6'h04, 32'h1A0); wr(6'h00, 32'h1);
    wait_idle();
    chk("R9 min idle >= 6", {31'b0, (min_idle >= 6)}, 32'h1);
    chk_copy("R9 copy", 32'h400, 32'hB00, 3);

    // R10 pause with slow responses
    wlat_min = 20;
    put_cb(32'h1C0, 32'h118, 32'h400, 32'hD00, 64, 32'h0);
    wr_cnt = 0; rd_cnt = 0;
    wr(6'h04, 32'h1C0); wr(6'h00, 32'h1);
    while (wr_cnt < 3) @(negedge clk);
    wr(6'h00, 32'h0);
    rd(6'h00, v);
    chk("R10 paused bit", (v >> 4) & 1, 32'h1);
    chk("R10 wait bit", (v >> 6) & 1, (out_cnt != 0) ? 32'h1 : 32'h0);
    repeat (5) @(negedge clk);
    snap = rd_cnt + wr_cnt;
    repeat (40) @(negedge clk);
    chk("R10 no requests while paused", rd_cnt + wr_cnt, snap);
    rd(6'h00, v);
    chk("R10 wait bit clear", (v >> 6) & 1, 32'h0);
    wlat_min = 1;
    wr(6'h00, 32'h1);
    wait_idle();
    chk_copy("R10 copy after resume", 32'h400, 32'hD00, 16);

    // R12 abort
    mem[32'hEFC/4] = 32'hA5A5_A5A5;
    mem[32'hF80/4] = 32'h0; mem[32'hF84/4] = 32'h0;
    put_cb(32'h1E0, 32'h110, 32'h400, 32'hE00, 256, 32'h240);
    put_cb(32'h240, 32'h111, 32'h500, 32'hF80, 8, 32'h0);
    wr(6'h00, 32'h7);
    wr(6'h04, 32'h1E0); wr(6'h00, 32'h1);
    repeat (25) @(negedge clk);
    wr(6'h00, 32'h4000_0001);
    wait_idle();
    chk("R12 aborted block stopped early", mem[32'hEFC/4], 32'hA5A5_A5A5);
    chk_copy("R12 next block ran", 32'h500, 32'hF80, 2);
    chk("R12 irq from next block", {31'b0, irq}, 32'h1);
    wr(6'h00, 32'h7);

    // R14 looping chain, then R13 channel reset
    put_cb(32'h200, 32'h101, 32'h400, 32'hFC0, 4, 32'h220);
    put_cb(32'h220, 32'h101, 32'h404, 32'hFC0, 4, 32'h200);
    wr(6'h04, 32'h200); wr(6'h00, 32'h1);
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      int n = 0;
      while (!irq && n < 2000) begin @(negedge clk); n++; end
      if (irq) cnt++;
      wr(6'h00, 32'h5);
    end
    chk("R14 loop interrupts", cnt, 3);
    rd(6'h04, v); chk("R14 still running", {31'b0, (v != 0)}, 32'h1);
    wr(6'h00, 32'h8000_0000);
    rd(6'h04, v); chk("R13 cb cleared", v, 32'h0);
    rd(6'h00, v); chk("R13 cs cleared", v & 32'h7, 32'h0);
    chk("R13 irq low", {31'b0, irq}, 32'h0);
    repeat (5) @(negedge clk);
    snap = rd_cnt + wr_cnt;
    repeat (40) @(negedge clk);
    chk("R13 no requests after reset", rd_cnt + wr_cnt, snap);

    finished = 1;
    summary();
    $finish;
  end
endmodule